// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

The block accepts an RGB pixel stream in raster order, one pixel per clock when the input valid is high. It turns each pixel into an 8-bit luma value. Two rows of luma are held in on-chip line buffers. The current pixel and these two rows feed a 3x3 window, which moves one column with every accepted pixel. Horizontal and vertical Sobel gradients are taken from the window. Their absolute values are added and the sum is saturated. The result is compared with a threshold that is latched once per frame. Each accepted pixel yields one binary output pixel, 0xFF for an edge and 0x00 otherwise. No multiplier is used on any path.

The output stream carries the same valid, start-of-frame and end-of-line markers as the input, delayed by a fixed three cycles. The decision at stream position (r, c) belongs to the window centred on (r-1, c-1). Because of this, the edge map comes out displaced by one pixel down and one pixel right, and every position whose window would leave the frame is forced to zero. The frame is 512x512 by default. Width and height are parameters.

Top module: `sobel_edge`

## Requirements
- R1: Luma is Y = (77·R + 150·G + 29·B) >> 8, where R is in_rgb_i[23:16], G is in_rgb_i[15:8] and B is in_rgb_i[7:0].
- R2: Writing the window as rows top to bottom and columns left to right, Gx is the right column minus the left column and Gy is the bottom row minus the top row. In both cases the three taps are weighted 1, 2, 1.
- R3: The magnitude is |Gx| + |Gy|, saturated to 255. The output is 0xFF when the magnitude is strictly greater than the threshold, otherwise 0x00. A magnitude equal to the threshold gives 0x00.
- R4: thresh_i is sampled with the start-of-frame pixel and applies to every pixel of that frame. Changes on thresh_i at any other time have no effect.
- R5: Output position (r, c) carries the decision for the window centred on (r-1, c-1). It is 0x00 whenever r < 2 or c < 2.
- R6: out_valid_o, out_sof_o and out_eol_o equal the accepted input valid, start-of-frame and end-of-line delayed by exactly 3 clock cycles. There is one output pixel per accepted input pixel, in input order.
- R7: Cycles with in_valid_i low change no result. All inputs other than in_valid_i are ignored during those cycles.
- R8: When frames arrive back to back, the outputs of each frame depend only on that frame's pixels and that frame's threshold.
- R9: After reset, out_valid_o, out_sof_o, out_eol_o and out_pix_o are all 0.
- R10: A start-of-frame pixel restarts row and column counting at (0, 0), even if the previous frame was cut short. in_eol_i is expected only on the last column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_sof_i | input | 1 | First pixel of a frame |
| in_eol_i | input | 1 | Last pixel of a row |
| in_rgb_i | input | 24 | Pixel colour, R high byte, B low byte |
| thresh_i | input | 8 | Edge threshold, sampled at start of frame |
| out_valid_o | output | 1 | Output pixel valid |
| out_sof_o | output | 1 | Output first pixel of a frame |
| out_eol_o | output | 1 | Output last pixel of a row |
| out_pix_o | output | 8 | Edge decision, 0xFF or 0x00 |

## Verification
The assertions assume a well-formed input stream. in_eol_i is raised only on a pixel that falls in the last column of the internal count, and a frame starts with in_sof_i on its first pixel. The latency checks rely on the valid pipeline having filled after reset. The directed stimulus meets all of these conditions. It sets end-of-line only on the last column of each row and marks start-of-frame only on pixel zero. It drives random values on start-of-frame, end-of-line and colour only in cycles where valid is low, which also exercises the requirement that idle cycles have no effect.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned RGB_W  = 3 * PIX_W;
  localparam int unsigned KERN   = 3;
  localparam int unsigned GRAD_W = PIX_W + 3;
  localparam int unsigned PIX_MAX = (1 << PIX_W) - 1;

  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [GRAD_W-1:0] grad_t;

  typedef struct packed {
    logic sof;
    logic eol;
    logic border;
    pix_t thr;
  } meta_t;
endpackage

// File: rtl/sobel_luma.sv
module sobel_luma
  import sobel_pkg::*;
(
  input  logic [RGB_W-1:0] rgb_i,
  output pix_t             y_o
);
  localparam int unsigned ACC_W = PIX_W + 8;

  logic [ACC_W-1:0] r, g, b, acc;

  always_comb begin
    r = ACC_W'(rgb_i[3*PIX_W-1:2*PIX_W]);
    g = ACC_W'(rgb_i[2*PIX_W-1:PIX_W]);
    b = ACC_W'(rgb_i[PIX_W-1:0]);
    // 77 = 64+8+4+1, 150 = 128+16+4+2, 29 = 16+8+4+1
    acc = (r << 6) + (r << 3) + (r << 2) + r
        + (g << 7) + (g << 4) + (g << 2) + (g << 1)
        + (b << 4) + (b << 3) + (b << 2) + b;
    y_o = acc[ACC_W-1:8];
  end
endmodule

// File: rtl/sobel_window.sv
module sobel_window
  import sobel_pkg::*;
#(
  parameter int unsigned IMG_W = 512,
  parameter int unsigned IMG_H = 512
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 valid_i,
  input  logic                                 sof_i,
  input  logic                                 eol_i,
  input  pix_t                                 y_i,
  output logic [KERN-1:0][KERN-1:0][PIX_W-1:0] win_o,
  output logic                                 border_o
);
  localparam int unsigned COL_W   = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int unsigned ROW_W   = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam int unsigned LB_ROWS = KERN - 1;

  logic [COL_W-1:0] col_q, cur_col;
  logic [ROW_W-1:0] row_q, cur_row;
  pix_t             lb_rd [LB_ROWS];

  assign cur_col = sof_i ? '0 : col_q;
  assign cur_row = sof_i ? '0 : row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      row_q    <= '0;
      border_o <= 1'b0;
    end else if (valid_i) begin
      border_o <= (cur_row < ROW_W'(KERN - 1)) || (cur_col < COL_W'(KERN - 1));
      if (cur_col == COL_W'(IMG_W - 1)) begin
        col_q <= '0;
        row_q <= (cur_row == ROW_W'(IMG_H - 1)) ? '0 : cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end

  // line buffer k holds the row k+1 above the current one
  for (genvar k = 0; k < LB_ROWS; k++) begin : g_lb
    pix_t mem_q [IMG_W];
    pix_t wr_d;
    if (k == 0) begin : g_first
      assign wr_d = y_i;
    end else begin : g_chain
      assign wr_d = lb_rd[k-1];
    end
    always_ff @(posedge clk_i) begin
      if (valid_i) mem_q[cur_col] <= wr_d;
    end
    assign lb_rd[k] = mem_q[cur_col];
  end

  // window row i: 0 = oldest row, KERN-1 = current row; column KERN-1 = newest
  for (genvar i = 0; i < KERN; i++) begin : g_row
    logic [KERN-1:0][PIX_W-1:0] row_q;
    pix_t src;
    if (i == KERN - 1) begin : g_cur
      assign src = y_i;
    end else begin : g_old
      assign src = lb_rd[KERN-2-i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      row_q <= '0;
      else if (valid_i) row_q <= {src, row_q[KERN-1:1]};
    end
    assign win_o[i] = row_q;
  end

  // R10
  eol_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eol_i) |-> (cur_col == COL_W'(IMG_W - 1)));
endmodule

// File: rtl/sobel_grad.sv
module sobel_grad
  import sobel_pkg::*;
(
  input  logic [KERN-1:0][KERN-1:0][PIX_W-1:0] win_i,
  output grad_t                                gx_o,
  output grad_t                                gy_o
);
  function automatic grad_t ext(input pix_t p);
    return grad_t'({{(GRAD_W-PIX_W){1'b0}}, p});
  endfunction

  grad_t left, right, top, bot;

  always_comb begin
    left  = ext(win_i[0][0]) + (ext(win_i[1][0]) <<< 1) + ext(win_i[2][0]);
    right = ext(win_i[0][2]) + (ext(win_i[1][2]) <<< 1) + ext(win_i[2][2]);
    top   = ext(win_i[0][0]) + (ext(win_i[0][1]) <<< 1) + ext(win_i[0][2]);
    bot   = ext(win_i[2][0]) + (ext(win_i[2][1]) <<< 1) + ext(win_i[2][2]);
    gx_o  = right - left;
    gy_o  = bot - top;
  end
endmodule

// File: rtl/sobel_mag.sv
module sobel_mag
  import sobel_pkg::*;
(
  input  grad_t gx_i,
  input  grad_t gy_i,
  input  pix_t  thr_i,
  input  logic  border_i,
  output pix_t  pix_o
);
  logic [GRAD_W-1:0] ax, ay, sum;
  pix_t              mag;

  always_comb begin
    ax    = gx_i[GRAD_W-1] ? GRAD_W'(-gx_i) : GRAD_W'(gx_i);
    ay    = gy_i[GRAD_W-1] ? GRAD_W'(-gy_i) : GRAD_W'(gy_i);
    sum   = ax + ay;
    mag   = (sum > GRAD_W'(PIX_MAX)) ? pix_t'(PIX_MAX) : sum[PIX_W-1:0];
    pix_o = (!border_i && (mag > thr_i)) ? pix_t'(PIX_MAX) : '0;
  end
endmodule

// File: rtl/sobel_edge.sv
module sobel_edge
  import sobel_pkg::*;
#(
  parameter int unsigned IMG_W = 512,
  parameter int unsigned IMG_H = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        in_sof_i,
  input  logic        in_eol_i,
  input  logic [23:0] in_rgb_i,
  input  logic [7:0]  thresh_i,
  output logic        out_valid_o,
  output logic        out_sof_o,
  output logic        out_eol_o,
  output logic [7:0]  out_pix_o
);
  pix_t  y, thr_q, thr_cur, edge_pix;
  logic  border1;
  logic  v1, v2;
  meta_t m1, m2;
  grad_t gx, gy, gx2, gy2;
  logic [KERN-1:0][KERN-1:0][PIX_W-1:0] win;

  sobel_luma u_luma (.rgb_i(in_rgb_i), .y_o(y));

  assign thr_cur = in_sof_i ? thresh_i : thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      thr_q <= '0;
    else if (in_valid_i && in_sof_i)  thr_q <= thresh_i;
  end

  sobel_window #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .sof_i   (in_sof_i),
    .eol_i   (in_eol_i),
    .y_i     (y),
    .win_o   (win),
    .border_o(border1)
  );

  // stage 1 markers; threshold travels with its pixel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0;
      m1 <= '0;
    end else begin
      v1 <= in_valid_i;
      if (in_valid_i) m1 <= '{sof: in_sof_i, eol: in_eol_i, border: 1'b0, thr: thr_cur};
    end
  end

  sobel_grad u_grad (.win_i(win), .gx_o(gx), .gy_o(gy));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2  <= 1'b0;
      m2  <= '0;
      gx2 <= '0;
      gy2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        m2  <= '{sof: m1.sof, eol: m1.eol, border: border1, thr: m1.thr};
        gx2 <= gx;
        gy2 <= gy;
      end
    end
  end

  sobel_mag u_mag (
    .gx_i    (gx2),
    .gy_i    (gy2),
    .thr_i   (m2.thr),
    .border_i(m2.border),
    .pix_o   (edge_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sof_o   <= 1'b0;
      out_eol_o   <= 1'b0;
      out_pix_o   <= '0;
    end else begin
      out_valid_o <= v2;
      out_sof_o   <= v2 && m2.sof;
      out_eol_o   <= v2 && m2.eol;
      out_pix_o   <= v2 ? edge_pix : '0;
    end
  end

  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   since_rst_q <= '0;
    else if (since_rst_q != 2'd3)  since_rst_q <= since_rst_q + 2'd1;
  end

  // R6
  lat_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));
  // R6
  lat_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) |-> (out_sof_o == ($past(in_valid_i, 3) && $past(in_sof_i, 3))));
  // R3
  out_binary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_pix_o == 8'h00 || out_pix_o == 8'hFF));
  // R5
  sof_border_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> (out_valid_o && out_pix_o == 8'h00));
endmodule

// File: tb/sobel_edge_tb.sv
`timescale 1ns/1ps
module sobel_edge_tb;
  localparam int W = 8;
  localparam int H = 6;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_ni, in_valid, in_sof, in_eol;
  logic [23:0] in_rgb;
  logic [7:0]  thresh;
  logic        out_valid, out_sof, out_eol;
  logic [7:0]  out_pix;

  sobel_edge #(.IMG_W(W), .IMG_H(H)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_sof_i(in_sof),
    .in_eol_i(in_eol), .in_rgb_i(in_rgb), .thresh_i(thresh),
    .out_valid_o(out_valid), .out_sof_o(out_sof), .out_eol_o(out_eol), .out_pix_o(out_pix)
  );

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R9";
  logic [23:0] rgb_arr [H][W];
  int          yarr    [H][W];
  int          q_pix[$], q_sof[$], q_eol[$], q_cyc[$];

  task automatic chk(string req, bit ok, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic monitor();
    if (out_valid) begin
      if (q_pix.size() == 0) begin
        chk(cur_req, 1'b0, "R6 unexpected output", 1, 0);
      end else begin
        int p = q_pix.pop_front();
        int s = q_sof.pop_front();
        int e = q_eol.pop_front();
        int c = q_cyc.pop_front();
        chk(cur_req, out_pix == p[7:0], "R5 pixel", out_pix, p);
        chk("R6", out_sof == s[0], "sof", out_sof, s);
        chk("R6", out_eol == e[0], "eol", out_eol, e);
        chk("R6", (cyc - c) == LAT, "latency", cyc - c, LAT);
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    monitor();
  endtask

  // R1: luma model
  task automatic fill(int pat);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        logic [23:0] v;
        case (pat)
          0: v = 24'h808080;
          1: v = (c >= W/2) ? 24'hFFFFFF : 24'h000000;
          2: v = (r >= H/2) ? 24'hFFFFFF : 24'h000000;
          4: v = {3{8'(c*10)}};
          default: v = 24'($urandom);
        endcase
        rgb_arr[r][c] = v;
        yarr[r][c] = (77*int'(v[23:16]) + 150*int'(v[15:8]) + 29*int'(v[7:0])) >> 8;
      end
  endtask

  function automatic int exp_at(int r, int c, int thr);
    int gx, gy, m;
    if (r < 2 || c < 2) return 0;
    gx = (yarr[r-2][c] + 2*yarr[r-1][c] + yarr[r][c])
       - (yarr[r-2][c-2] + 2*yarr[r-1][c-2] + yarr[r][c-2]);
    gy = (yarr[r][c-2] + 2*yarr[r][c-1] + yarr[r][c])
       - (yarr[r-2][c-2] + 2*yarr[r-2][c-1] + yarr[r-2][c]);
    m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    if (m > 255) m = 255;
    return (m > thr) ? 255 : 0;
  endfunction

  task automatic drive_frame(int npix, int thr, bit gaps, bit wiggle);
    for (int i = 0; i < npix; i++) begin
      int r = i / W;
      int c = i % W;
      if (gaps) begin
        while ($urandom % 3 == 0) begin
          in_valid = 1'b0;
          in_rgb   = 24'($urandom);
          in_sof   = 1'($urandom);
          in_eol   = 1'($urandom);
          thresh   = 8'($urandom);
          tick();
        end
      end
      in_valid = 1'b1;
      in_rgb   = rgb_arr[r][c];
      in_sof   = (i == 0);
      in_eol   = (c == W - 1);
      thresh   = (i == 0 || !wiggle) ? 8'(thr) : 8'($urandom);
      q_pix.push_back(exp_at(r, c, thr));
      q_sof.push_back(i == 0);
      q_eol.push_back(c == W - 1);
      q_cyc.push_back(cyc);
      tick();
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 3) tick();
    chk(cur_req, q_pix.size() == 0, "R6 outputs missing", q_pix.size(), 0);
    q_pix.delete(); q_sof.delete(); q_eol.delete(); q_cyc.delete();
  endtask

  task automatic t_reset();
    cur_req = "R9";
    rst_ni = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    in_rgb = '0; thresh = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    chk("R9", out_valid == 1'b0, "reset valid", out_valid, 0);
    chk("R9", out_sof == 1'b0, "reset sof", out_sof, 0);
    chk("R9", out_eol == 1'b0, "reset eol", out_eol, 0);
    chk("R9", out_pix == 8'h00, "reset pix", out_pix, 0);
  endtask

  task automatic t_flat();
    cur_req = "R3";
    fill(0); drive_frame(W*H, 0, 1'b0, 1'b0); drain();
  endtask

  task automatic t_vertical();
    cur_req = "R2";
    fill(1); drive_frame(W*H, 100, 1'b0, 1'b0); drain();
  endtask

  task automatic t_horizontal();
    cur_req = "R2";
    fill(2); drive_frame(W*H, 100, 1'b0, 1'b0); drain();
  endtask

  // R3: ramp magnitude is 80, step edge saturates to 255
  task automatic t_threshold();
    cur_req = "R3";
    fill(4); drive_frame(W*H, 80, 1'b0, 1'b0); drain();
    fill(4); drive_frame(W*H, 79, 1'b0, 1'b0); drain();
    fill(1); drive_frame(W*H, 254, 1'b0, 1'b0); drain();
    fill(1); drive_frame(W*H, 255, 1'b0, 1'b0); drain();
  endtask

  task automatic t_random_gaps();
    cur_req = "R7";
    fill(3); drive_frame(W*H, 60, 1'b1, 1'b0); drain();
    cur_req = "R1";
    fill(3); drive_frame(W*H, 30, 1'b0, 1'b0); drain();
  endtask

  task automatic t_thresh_hold();
    cur_req = "R4";
    fill(3); drive_frame(W*H, 90, 1'b0, 1'b1); drain();
  endtask

  task automatic t_back_to_back();
    cur_req = "R8";
    fill(3); drive_frame(W*H, 200, 1'b0, 1'b0);
    fill(1); drive_frame(W*H, 20, 1'b0, 1'b0);
    fill(3); drive_frame(W*H, 10, 1'b1, 1'b1);
    drain();
  endtask

  task automatic t_restart();
    cur_req = "R10";
    fill(3); drive_frame(2*W + 3, 40, 1'b0, 1'b0);
    fill(2); drive_frame(W*H, 40, 1'b0, 1'b0);
    drain();
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_flat();
    t_vertical();
    t_horizontal();
    t_threshold();
    t_random_gaps();
    t_thresh_hold();
    t_back_to_back();
    t_restart();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL %s watchdog expired actual=%0d expected=%0d", cur_req, cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule